// File: doc/BRIEF.md
# Battery-Domain Wake and Interrupt Controller

This block holds the extended-control logic of a battery-backed clock. An 8-bit control register is written and read over a small parallel register bus. Its bits set the following:
- how the power-control pin behaves,
- which sources may raise an interrupt,
- whether the 32.768 kHz clock reaches the square-wave output,
- whether an external pin may wipe the user RAM.

Two sticky event flags record wake-up and kickstart events. A kickstart is a low pulse on an asynchronous pin. A wake-up is a one-cycle strobe from the alarm logic. Enabled flags pull the active-low power-control output low in every supply state. They pull the active-low interrupt output low only while main supply is present. As a result, an event during power fail asserts the power pin at once, and the interrupt follows when supply returns.

A RAM-clear sequencer walks the user RAM one byte per clock and writes zero to each byte. It raises a completion flag that can also drive the interrupt. A separate flags register, read-cleared by the host, reports the three flags and the sequencer's busy state.

Top module: `rtc_wake_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x40, the flags register (address 1) reads 0x00, `irq_n` and `pwr_ctl_n` are 1, and `clr_busy` and `ram_we` are 0.
- R2: While `main_ok` is 1, a write to address 0 loads the control register and the value reads back unchanged. The bit meanings are: bit 7 `aux_en`, bit 6 32 kHz enable, bit 5 `xtal_sel`, bit 4 clear enable, bit 3 power-pin hold, bit 2 clear-done interrupt enable, bit 1 wake enable, bit 0 kick enable. Writes made while `main_ok` is 0 are ignored.
- R3: A rise of `main_ok` sets control bit 6 at the next clock edge, and this takes priority over a write in the same cycle. `sqw_32k_en` equals control bit 6.
- R4: A falling edge on `kick_n` sets the kick flag (flags bit 0) within four clocks.
- R5: A `wake_evt` strobe sets the wake flag (flags bit 1) at the next clock edge.
- R6: While `main_ok` is 0, an enabled set flag drives `pwr_ctl_n` low and `irq_n` stays 1. Once `main_ok` returns, `irq_n` goes low.
- R7: While `main_ok` is 1, an enabled set flag drives both `pwr_ctl_n` and `irq_n` low.
- R8: A flag whose enable bit is 0 has no effect on `pwr_ctl_n` or `irq_n`.
- R9: `pwr_ctl_oe` is 1 while `main_ok` is 1. While `main_ok` is 0 it equals control bit 3.
- R10: With control bit 4 at 1, a falling edge on `clr_req_n` starts a walk of exactly 114 write cycles. The walk drives `ram_addr` 0 to 113 in order, with `ram_wdata` 0 and `clr_busy` high. With bit 4 at 0, the pin is ignored.
- R11: The end of a walk sets the clear-done flag (flags bit 2). With control bit 2 at 1, this drives `irq_n` low. Flags bit 7 reports `clr_busy`.
- R12: A read of address 1 while `main_ok` is 1 clears flags bits 0 to 2 at that clock edge. A new event in the same cycle wins. The outputs then release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Battery-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok | input | 1 | Main supply present |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear of flags) |
| reg_addr | input | 1 | 0 = control, 1 = flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| kick_n | input | 1 | Asynchronous kickstart pin, active low |
| wake_evt | input | 1 | Synchronous wake-up strobe |
| clr_req_n | input | 1 | Asynchronous RAM-clear request pin, active low |
| ram_we | output | 1 | User-RAM write enable |
| ram_addr | output | 7 | User-RAM byte address |
| ram_wdata | output | 8 | User-RAM write data (always zero) |
| clr_busy | output | 1 | Clear walk in progress |
| aux_en | output | 1 | Auxiliary supply input enable (control bit 7) |
| xtal_sel | output | 1 | Crystal load select (control bit 5) |
| sqw_32k_en | output | 1 | Route 32.768 kHz to square-wave output |
| pwr_ctl_n | output | 1 | Power-control output value, active low |
| pwr_ctl_oe | output | 1 | Power-control output enable (0 = high impedance) |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions take `main_ok`, `wake_evt` and the register strobes to be synchronous to `clk`. Only `kick_n` and `clr_req_n` pass through synchronizers. The bench therefore changes every input on the falling clock edge. It holds each kick pulse for several clocks, which is longer than the synchronizer latency. It always clears the clear-enable bit in its random control writes, so no walk starts unseen. Random register values, supply states and event sources are mixed with directed cases: writes while power is off, disabled sources, and both enabled and ignored clear requests.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  typedef struct packed {
    logic aux_en;
    logic clk32_en;
    logic xtal_sel;
    logic clr_en;
    logic hold_drive;
    logic clr_ie;
    logic wake_ie;
    logic kick_ie;
  } ext_ctrl_t;

  localparam logic [7:0] CTRL_RST   = 8'h40;
  localparam logic       ADDR_CTRL  = 1'b0;
  localparam logic       ADDR_FLAGS = 1'b1;
endpackage

// File: rtl/rtc_fall_sync.sv
module rtc_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] q_r, q_nxt;

  always_comb q_nxt = {q_r[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '1;
    else        q_r <= q_nxt;
  end

  assign fall = q_r[STAGES] & ~q_r[STAGES-1];
endmodule

// File: rtl/rtc_ram_clear.sv
module rtc_ram_clear #(
  parameter int DEPTH = 114,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_r, busy_nxt;
  logic [AW-1:0] cnt_r, cnt_nxt;
  logic          at_last;

  assign at_last = (cnt_r == LAST);

  always_comb begin
    busy_nxt = busy_r;
    cnt_nxt  = cnt_r;
    if (busy_r) begin
      if (at_last) busy_nxt = 1'b0;
      else         cnt_nxt  = cnt_r + AW'(1);
    end else if (start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      cnt_r  <= '0;
    end else begin
      busy_r <= busy_nxt;
      cnt_r  <= cnt_nxt;
    end
  end

  assign busy = busy_r;
  assign addr = cnt_r;
  assign done = busy_r & at_last;
endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
  import rtc_wake_pkg::*;
#(
  parameter int RAM_BYTES   = 114,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = $clog2(RAM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_ok,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          kick_n,
  input  logic          wake_evt,
  input  logic          clr_req_n,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          clr_busy,
  output logic          aux_en,
  output logic          xtal_sel,
  output logic          sqw_32k_en,
  output logic          pwr_ctl_n,
  output logic          pwr_ctl_oe,
  output logic          irq_n
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_r;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_i_n = rst_sync_r[1];

  // pin synchronizers with falling-edge detect
  logic kick_fall, clr_fall;
  rtc_fall_sync #(.STAGES(SYNC_STAGES)) u_kick_sync (
    .clk(clk), .rst_n(rst_i_n), .din(kick_n), .fall(kick_fall));
  rtc_fall_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst_n(rst_i_n), .din(clr_req_n), .fall(clr_fall));

  ext_ctrl_t ctrl_r, ctrl_nxt;
  logic      kf_r, kf_nxt, wf_r, wf_nxt, cdf_r, cdf_nxt;
  logic      on_r;
  logic      wr_ctrl, rd_clr, power_up;
  logic      seq_start, seq_busy, seq_done;
  logic      pend_wake_side, pend_any;

  assign wr_ctrl  = reg_wr & main_ok & (reg_addr == ADDR_CTRL);
  assign rd_clr   = reg_rd & main_ok & (reg_addr == ADDR_FLAGS);
  assign power_up = main_ok & ~on_r;

  assign seq_start = ctrl_r.clr_en & clr_fall;

  rtc_ram_clear #(.DEPTH(RAM_BYTES), .AW(AW)) u_clear (
    .clk(clk), .rst_n(rst_i_n), .start(seq_start),
    .busy(seq_busy), .addr(ram_addr), .done(seq_done));

  always_comb begin
    ctrl_nxt = ctrl_r;
    if (wr_ctrl)  ctrl_nxt = ext_ctrl_t'(reg_wdata);
    if (power_up) ctrl_nxt.clk32_en = 1'b1;
    kf_nxt  = (kf_r  & ~rd_clr) | kick_fall;
    wf_nxt  = (wf_r  & ~rd_clr) | wake_evt;
    cdf_nxt = (cdf_r & ~rd_clr) | seq_done;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_r <= ext_ctrl_t'(CTRL_RST);
      kf_r   <= 1'b0;
      wf_r   <= 1'b0;
      cdf_r  <= 1'b0;
      on_r   <= 1'b0;
    end else begin
      ctrl_r <= ctrl_nxt;
      kf_r   <= kf_nxt;
      wf_r   <= wf_nxt;
      cdf_r  <= cdf_nxt;
      on_r   <= main_ok;
    end
  end

  assign pend_wake_side = (ctrl_r.kick_ie & kf_r) | (ctrl_r.wake_ie & wf_r);
  assign pend_any       = pend_wake_side | (ctrl_r.clr_ie & cdf_r);

  assign pwr_ctl_n  = ~pend_wake_side;
  assign pwr_ctl_oe = main_ok | ctrl_r.hold_drive;
  assign irq_n      = ~(main_ok & pend_any);

  assign reg_rdata = (reg_addr == ADDR_FLAGS) ? {seq_busy, 4'b0000, cdf_r, wf_r, kf_r}
                                              : ctrl_r;

  assign ram_we     = seq_busy;
  assign ram_wdata  = 8'h00;
  assign clr_busy   = seq_busy;
  assign aux_en     = ctrl_r.aux_en;
  assign xtal_sel   = ctrl_r.xtal_sel;
  assign sqw_32k_en = ctrl_r.clk32_en;
endmodule

// File: rtl/rtc_wake_chk.sv
module rtc_wake_chk #(
  parameter int RAM_BYTES = 114,
  parameter int AW        = $clog2(RAM_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          main_ok,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [7:0]    ram_wdata,
  input logic          clr_busy,
  input logic          sqw_32k_en,
  input logic          pwr_ctl_oe,
  input logic          irq_n
);
  // R6
  no_irq_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |-> irq_n);

  // R9
  pwr_driven_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_ok |-> pwr_ctl_oe);

  // R3
  powerup_clk32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_ok) |=> sqw_32k_en);

  // R10
  clear_zero_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (clr_busy && ram_wdata == 8'h00 && ram_addr <= AW'(RAM_BYTES - 1)));

  // R10
  clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> ram_addr == AW'($past(ram_addr) + AW'(1)));

  // R10
  clear_first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_busy) |-> ram_addr == '0);
endmodule

bind rtc_wake_ctrl rtc_wake_chk #(.RAM_BYTES(RAM_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .ram_we(ram_we),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .clr_busy(clr_busy),
  .sqw_32k_en(sqw_32k_en), .pwr_ctl_oe(pwr_ctl_oe), .irq_n(irq_n));

// File: tb/sim_rtc_wake_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_wake_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, main_ok, reg_wr, reg_rd, reg_addr, kick_n, wake_evt, clr_req_n;
  logic [7:0] reg_wdata, reg_rdata, ram_wdata;
  logic [6:0] ram_addr;
  logic       ram_we, clr_busy, aux_en, xtal_sel, sqw_32k_en, pwr_ctl_n, pwr_ctl_oe, irq_n;

  rtc_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .kick_n(kick_n), .wake_evt(wake_evt), .clr_req_n(clr_req_n),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .clr_busy(clr_busy),
    .aux_en(aux_en), .xtal_sel(xtal_sel), .sqw_32k_en(sqw_32k_en),
    .pwr_ctl_n(pwr_ctl_n), .pwr_ctl_oe(pwr_ctl_oe), .irq_n(irq_n));

  int errs = 0, nchk = 0;
  logic [7:0] m_ctrl;
  logic       m_kf, m_wf, m_cdf, m_on;
  bit         done_flag = 0;

  function automatic logic e_pwr_n();
    return !((m_ctrl[0] & m_kf) | (m_ctrl[1] & m_wf));
  endfunction
  function automatic logic e_irq_n();
    return !(m_on & ((m_ctrl[0] & m_kf) | (m_ctrl[1] & m_wf) | (m_ctrl[2] & m_cdf)));
  endfunction
  function automatic logic e_oe();
    return m_on | m_ctrl[3];
  endfunction
  function automatic logic [7:0] e_flags();
    return {5'b00000, m_cdf, m_wf, m_kf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (m_on && a == 1'b0) m_ctrl = d;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 1'b0;
    #1 v = reg_rdata;
  endtask

  task automatic rd_flags(output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    if (m_on) begin m_kf = 0; m_wf = 0; m_cdf = 0; end
  endtask

  task automatic kick();
    @(negedge clk); kick_n = 1'b0;
    cyc(4);
    m_kf = 1'b1;
    kick_n = 1'b1;
    cyc(3);
  endtask

  task automatic wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    m_wf = 1'b1;
  endtask

  task automatic power(input logic v);
    @(negedge clk); main_ok = v;
    if (v && !m_on) m_ctrl[6] = 1'b1;
    m_on = v;
    cyc(1);
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [7:0] v;
    int n;
    bit seen, any_we;
    void'($urandom(32'd7321));
    rst_n = 0; main_ok = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    kick_n = 1; wake_evt = 0; clr_req_n = 1;
    m_ctrl = 8'h40; m_kf = 0; m_wf = 0; m_cdf = 0; m_on = 1;
    cyc(3); rst_n = 1; cyc(3);

    // R1 reset state
    rd_ctrl(v);  chk("R1 ctrl", v, 8'h40);
    @(negedge clk); reg_addr = 1'b1; #1 chk("R1 flags", reg_rdata, 8'h00);
    chk("R1 irq_n", irq_n, 1); chk("R1 pwr_ctl_n", pwr_ctl_n, 1);
    chk("R1 busy", clr_busy, 0); chk("R1 ram_we", ram_we, 0);

    // R2 write/readback and bit fields
    wr(0, 8'hA5);
    rd_ctrl(v); chk("R2 readback", v, 8'hA5);
    chk("R2 aux_en", aux_en, 1); chk("R2 xtal_sel", xtal_sel, 1);
    chk("R3 sqw follows bit6", sqw_32k_en, 0);

    // R2 writes ignored off-supply, R9 float, R3 power-up force
    power(0);
    chk("R9 oe off hold0", pwr_ctl_oe, 0);
    wr(0, 8'h0F);
    power(1);
    rd_ctrl(v); chk("R2 unpowered write ignored + R3 force", v, 8'hE5);
    chk("R3 sqw", sqw_32k_en, 1);

    // R8 disabled sources
    wr(0, 8'h40);
    kick(); wake();
    chk("R8 pwr_ctl_n", pwr_ctl_n, 1); chk("R8 irq_n", irq_n, 1);
    rd_flags(v); chk("R4 R5 flags", v, 8'h03);
    rd_flags(v); chk("R12 cleared", v, 8'h00);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c, ef;
      bit off;
      c = 8'($urandom); c[4] = 1'b0;
      wr(0, c);
      rd_ctrl(v); chk("R2 random readback", v, m_ctrl);
      off = 1'($urandom % 2);
      if (off) begin
        power(0);
        chk("R9 oe", pwr_ctl_oe, e_oe());
      end
      if ($urandom % 2) kick(); else wake();
      chk("R6 R7 R8 pwr_ctl_n", pwr_ctl_n, e_pwr_n());
      chk("R6 R7 R8 irq_n", irq_n, e_irq_n());
      if (off) begin
        power(1);
        chk("R6 irq after return", irq_n, e_irq_n());
        chk("R3 sqw after return", sqw_32k_en, 1);
      end
      ef = e_flags();
      rd_flags(v); chk("R4 R5 flags", v, ef);
      chk("R12 irq released", irq_n, 1); chk("R12 pwr released", pwr_ctl_n, 1);
    end

    // R10 clear pin ignored when disabled
    wr(0, 8'h44);
    @(negedge clk); clr_req_n = 1'b0;
    any_we = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (ram_we || clr_busy) any_we = 1; end
    chk("R10 ignored when disabled", any_we, 0);
    clr_req_n = 1'b1; cyc(4);

    // R10 R11 enabled walk
    wr(0, 8'h54);
    @(negedge clk); clr_req_n = 1'b0;
    n = 0; seen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ram_we) begin
        seen = 1;
        if (n == 5) begin reg_addr = 1'b1; #1 chk("R11 busy bit", reg_rdata[7], 1); end
        chk("R10 addr", ram_addr, n);
        chk("R10 data", ram_wdata, 0);
        n++;
      end else if (seen) break;
    end
    clr_req_n = 1'b1;
    m_cdf = 1'b1;
    chk("R10 count", n, 114);
    chk("R11 irq", irq_n, 0);
    rd_flags(v); chk("R11 flag", v, 8'h04);
    chk("R12 irq released", irq_n, 1);

    cyc(4);
    report();
  end
endmodule